// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block keeps a running sum of products of two signed integer operands, one 12 bits wide and one 8 bits wide. A new operand pair is accepted on every clock. Each pair is first registered, then multiplied in a multiplier pipeline whose depth is set at build time. The 20-bit product is sign-extended and added into a 27-bit accumulator. The accumulator passes through one output register before it reaches the pin. The sum wraps modulo 2^27 and never saturates.

A per-sample clear input travels down the pipeline next to its operands. When a clear reaches the accumulator together with its own product, that product is discarded and the sum becomes zero. A global synchronous reset empties every stage. After reset, a valid flag rises once the first accepted sample has reached the output.

Top module: `smac_pipe`

## Requirements
- R1: While `rst` is high, every clock edge sets `acc_out` to 0 and `out_valid` to 0.
- R2: A sample is captured on clock edge n. Its effect appears on `acc_out` just after edge n+MUL_LAT+2, so the total latency is MUL_LAT+3 edges. `out_valid` first goes high just after edge number MUL_LAT+3 that has `rst` low. With MUL_LAT=3, every output event comes exactly one clock later than with MUL_LAT=2.
- R3: When its clear bit is 0, a sample adds the product `a_in*b_in` to the sum. Both operands are two's-complement integers with no fractional bits. The 20-bit product is sign-extended to 27 bits before the add.
- R4: The sum is kept modulo 2^27. An overflow in either direction wraps around and does not saturate.
- R5: A sample with `clr_in`=1 discards its own product. The output for that sample is 0, so a run of cleared samples reads 0 throughout.
- R6: For the first sample with `clr_in`=0 after one or more cleared samples, the output equals that sample's product alone.
- R7: Once `out_valid` is high, it stays high until `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Global synchronous reset, active high; clears all stages |
| a_in | input | 12 | Signed operand A, two's complement |
| b_in | input | 8 | Signed operand B, two's complement |
| clr_in | input | 1 | Active-high accumulator clear for this sample |
| acc_out | output | 27 | Registered running sum, two's complement, wraps modulo 2^27 |
| out_valid | output | 1 | High once the first post-reset sample has reached `acc_out` |

## Verification
On every cycle, the assertions check the following against delayed copies of the inputs:
- the step between consecutive outputs equals the sign-extended product of the sample that just arrived;
- a cleared sample reads zero;
- a restart yields the bare product;
- the valid flag rises at the right count and then holds.

The bench scenarios show the end-to-end behaviour that a one-cycle relation cannot pin down:
- the absolute running totals over long sequences;
- the actual wrap past 2^27 after hundreds of maximum-magnitude products;
- the operand extremes;
- the reset state itself.

// File: rtl/smac_pipe.sv
module smac_pipe #(
  parameter int A_W     = 12,
  parameter int B_W     = 8,
  parameter int ACC_W   = 27,
  parameter int MUL_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic             clr_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             out_valid
);
  localparam int P_W     = A_W + B_W;
  localparam int LO_W    = B_W / 2;
  localparam int HI_W    = B_W - LO_W;
  localparam int OUT_LAT = MUL_LAT + 3;

  logic [A_W-1:0]   a_q;
  logic [B_W-1:0]   b_q;
  logic             clr_q;
  logic [P_W-1:0]   pp_lo_q, pp_hi_q;
  logic [P_W-1:0]   prod_pipe [2:MUL_LAT];
  logic             clr_pipe  [1:MUL_LAT];
  logic [ACC_W-1:0] acc_q;
  logic [OUT_LAT-1:0] vld_q;

  wire [P_W-1:0] a_x  = {{B_W{a_q[A_W-1]}}, a_q};
  wire [P_W-1:0] lo_x = {{(P_W-LO_W){1'b0}}, b_q[LO_W-1:0]};
  wire [P_W-1:0] hi_x = {{(P_W-HI_W){b_q[B_W-1]}}, b_q[B_W-1:LO_W]};

  wire [P_W-1:0]   product = prod_pipe[MUL_LAT];
  wire             clr_al  = clr_pipe[MUL_LAT];
  wire [ACC_W-1:0] prod_x  = {{(ACC_W-P_W){product[P_W-1]}}, product};

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      clr_q <= 1'b0;
    end else begin
      a_q   <= a_in;
      b_q   <= b_in;
      clr_q <= clr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pp_lo_q      <= '0;
      pp_hi_q      <= '0;
      prod_pipe[2] <= '0;
      clr_pipe[1]  <= 1'b0;
    end else begin
      pp_lo_q      <= a_x * lo_x;
      pp_hi_q      <= a_x * hi_x;
      prod_pipe[2] <= pp_lo_q + (pp_hi_q << LO_W);
      clr_pipe[1]  <= clr_q;
    end
  end

  for (genvar k = 2; k <= MUL_LAT; k++) begin : g_clr_dly
    always_ff @(posedge clk) begin
      if (rst) clr_pipe[k] <= 1'b0;
      else     clr_pipe[k] <= clr_pipe[k-1];
    end
  end

  for (genvar k = 3; k <= MUL_LAT; k++) begin : g_prod_dly
    always_ff @(posedge clk) begin
      if (rst) prod_pipe[k] <= '0;
      else     prod_pipe[k] <= prod_pipe[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      acc_out <= '0;
      vld_q   <= '0;
    end else begin
      acc_q   <= clr_al ? '0 : acc_q + prod_x;
      acc_out <= acc_q;
      vld_q   <= {vld_q[OUT_LAT-2:0], 1'b1};
    end
  end

  assign out_valid = vld_q[OUT_LAT-1];
endmodule

// File: rtl/smac_pipe_chk.sv
module smac_pipe_chk #(
  parameter int A_W     = 12,
  parameter int B_W     = 8,
  parameter int ACC_W   = 27,
  parameter int MUL_LAT = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [A_W-1:0]   a_in,
  input logic [B_W-1:0]   b_in,
  input logic             clr_in,
  input logic [ACC_W-1:0] acc_out,
  input logic             out_valid
);
  localparam int OUT_LAT = MUL_LAT + 3;
  localparam int CNT_W   = $clog2(OUT_LAT + 2) + 1;

  logic [A_W-1:0] a_d   [OUT_LAT];
  logic [B_W-1:0] b_d   [OUT_LAT];
  logic           clr_d [OUT_LAT];
  logic [CNT_W-1:0] cnt_q;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < OUT_LAT; i++) begin
        a_d[i] <= '0; b_d[i] <= '0; clr_d[i] <= 1'b0;
      end
    end else begin
      if (cnt_q <= CNT_W'(OUT_LAT)) cnt_q <= cnt_q + 1'b1;
      a_d[0] <= a_in; b_d[0] <= b_in; clr_d[0] <= clr_in;
      for (int i = 1; i < OUT_LAT; i++) begin
        a_d[i] <= a_d[i-1]; b_d[i] <= b_d[i-1]; clr_d[i] <= clr_d[i-1];
      end
    end
  end

  wire [ACC_W-1:0] ax  = {{(ACC_W-A_W){a_d[OUT_LAT-1][A_W-1]}}, a_d[OUT_LAT-1]};
  wire [ACC_W-1:0] bx  = {{(ACC_W-B_W){b_d[OUT_LAT-1][B_W-1]}}, b_d[OUT_LAT-1]};
  wire [ACC_W-1:0] pe  = ax * bx;
  wire             clr_o = clr_d[OUT_LAT-1];

  always_ff @(posedge clk) begin
    if (rst_q) assert_reset_clear_R1: assert (acc_out == '0 && !out_valid);
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> cnt_q == CNT_W'(OUT_LAT));

  assert_accum_wrap_R3_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !clr_o) |-> acc_out == $past(acc_out) + pe);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && clr_o) |-> acc_out == '0);

  assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $fell(clr_o)) |-> acc_out == pe);

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
endmodule

bind smac_pipe smac_pipe_chk #(.A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .MUL_LAT(MUL_LAT)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .clr_in(clr_in),
  .acc_out(acc_out), .out_valid(out_valid)
);

// File: tb/smac_pipe_tb.sv
module smac_pipe_tb;
  localparam int MUL_LAT = 2;
  localparam int OUT_LAT = MUL_LAT + 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [11:0] a_in = '0;
  logic [7:0]  b_in = '0;
  logic        clr_in = 1'b1;
  wire  [26:0] acc_out;
  wire         out_valid;

  smac_pipe #(.A_W(12), .B_W(8), .ACC_W(27), .MUL_LAT(MUL_LAT)) u_dut (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .clr_in(clr_in),
    .acc_out(acc_out), .out_valid(out_valid)
  );

  typedef struct {
    logic [26:0] v;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [26:0] model = '0;
  bit          seen = 0;
  int          lat_cnt = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive(int a, int b, bit c, string tag);
    a_in   = a[11:0];
    b_in   = b[7:0];
    clr_in = c;
    if (c) model = '0;
    else   model = model + 27'(a * b);
    sb.push_back('{model, tag});
    @(negedge clk);
  endtask

  always begin
    item_t it;
    @(posedge clk);
    #1;
    if (rst) begin
      check(acc_out == '0 && !out_valid, "R1 reset state", longint'(acc_out) + longint'(out_valid), 0);
    end else begin
      if (!seen) begin
        lat_cnt++;
        if (out_valid) begin
          seen = 1;
          check(lat_cnt == OUT_LAT, "R2 first valid edge", lat_cnt, OUT_LAT);
        end
      end else begin
        check(out_valid, "R7 valid held", longint'(out_valid), 1);
      end
      if (out_valid && sb.size() > 0) begin
        it = sb.pop_front();
        check(acc_out == it.v, it.tag, longint'(acc_out), longint'(it.v));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    drive(1000, 50, 1, "R5 clear run");
    drive(-700, -3, 1, "R5 clear run");
    drive(2047, 127, 1, "R5 clear run");
    drive(3, 4, 0, "R6 restart");
    drive(-5, 7, 0, "R3 mixed sign");
    drive(100, -2, 0, "R3 mixed sign");
    drive(-2048, 127, 0, "R3 extreme");
    drive(2047, -128, 0, "R3 extreme");
    drive(-1, -1, 0, "R3 small neg");
    drive(0, 99, 0, "R3 zero operand");
    drive(5, 5, 1, "R5 single clear");
    drive(-7, 9, 0, "R6 restart after pulse");
    drive(11, 11, 0, "R3 after restart");
    drive(0, 0, 1, "R5 clear before wrap");
    for (int i = 0; i < 600; i++) drive(-2048, -128, 0, "R4 positive wrap");
    drive(1, 1, 1, "R5 clear before negative wrap");
    for (int i = 0; i < 520; i++) drive(2047, -128, 0, "R4 negative wrap");
    for (int i = 0; i < 40; i++) drive(i * 97 - 1900, (i * 13) % 256 - 128, 0, "R3 sweep");
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    summary();
  end
endmodule